// File: doc/BRIEF.md
# Polyphase Pulse-Shaping Interpolator

This block raises the sample rate of a stream of signed symbols by an integer factor L and shapes it with an FIR pulse whose impulse response reaches M symbol periods to either side of its centre. The upsampled stream is never built with zeros. The last 2M+1 real symbols are kept in a short history. A phase counter that wraps every L clocks chooses which group of 2M+1 coefficients to apply to that history, so the block makes one filtered sample on every clock and takes one symbol every L clocks.

The 2M+1 products are summed in a systolic chain and not in an adder tree. Each stage of the chain receives a copy of the history and phase that has been delayed by one clock per stage, so the partial sum and the stage's own product always belong to the same output. The final sum is rounded and then saturated to the symbol width. Coefficients are written through a single-word port while the filter is stopped.

Top module: `pulse_interp`

## Requirements
- R1: A synchronous reset clears the history, the coefficients, the phase and the output sample to zero, and holds `out_valid` low. With `enable` low, `sym_ready` is low.
- R2: While `enable` is high, `sym_ready` is high on exactly one cycle in every L. That is the first enabled cycle and then every L-th cycle after it. While `enable` is low, `sym_ready` is low and the phase returns to zero.
- R3: Let p be the phase of a cycle and h[k] the history entry k as updated in that cycle, with k=0 the newest symbol. The sample produced for that cycle is the sum over k of coef[p*(2M+1)+k]*h[k], using signed arithmetic at full precision.
- R4: The cycle on which a symbol is accepted uses phase 0, and the following L-1 cycles use phases 1 to L-1 in order.
- R5: The history shifts only on a `sym_ready` cycle. The shift brings in `sym_data` when `sym_valid` is high and zero when it is low. The history keeps its contents while `enable` is low.
- R6: The sample for an enabled cycle appears at the output L_AT = 2M+3 clock edges later, counting that cycle's edge, and `out_valid` is high exactly when that cycle was enabled. As a result, outputs follow on every cycle while `enable` stays high.
- R7: The sum has 2^(FRAC-1) added to it and is then shifted arithmetically right by FRAC, which rounds half upward (FRAC=15). The result is clamped to the range -32768 to 32767.
- R8: A write with `coef_we` high stores `coef_data` at address phase*(2M+1)+tap, but only while `enable` is low. Writes made while `enable` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the filter; while low, coefficients may be written |
| sym_valid | input | 1 | A symbol is offered |
| sym_data | input | DW | Signed symbol |
| sym_ready | output | 1 | The symbol is taken on this cycle |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | clog2(L*(2M+1)) | Coefficient address, phase*(2M+1)+tap |
| coef_data | input | CW | Signed coefficient |
| out_valid | output | 1 | The output sample is valid |
| out_data | output | DW | Signed filtered sample, rounded and saturated |

## Verification
The assertions are evaluated on every cycle. They check the reset state, that two `sym_ready` pulses are never on adjacent cycles, that the history is frozen off the accept cycle, that the coefficients are frozen while running, that `out_valid` is high once the filter has run for the full latency, and that a non-negative sum never produces a negative output. Only the bench scenarios can show the exact sample values. These depend on the phase order, the tap alignment through the skewed chain, the insertion of zero for a missing symbol, the rounding and the clamping, and they are compared against an independent model across impulse, random, gapped, paused and saturating streams.

// File: rtl/pulse_interp.sv
module pulse_interp #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int L    = 4,
  parameter int M    = 2,
  parameter int FRAC = 15
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  enable,
  input  logic                                  sym_valid,
  input  logic [DW-1:0]                         sym_data,
  output logic                                  sym_ready,
  input  logic                                  coef_we,
  input  logic [$clog2(L*(2*M+1))-1:0]          coef_addr,
  input  logic [CW-1:0]                         coef_data,
  output logic                                  out_valid,
  output logic [DW-1:0]                         out_data
);
  localparam int T   = 2*M + 1;
  localparam int NC  = L*T;
  localparam int AW  = $clog2(NC);
  localparam int PW  = (L > 1) ? $clog2(L) : 1;
  localparam int SW  = DW + CW + $clog2(T) + 1;
  localparam int LAT = T + 2;
  localparam int RW  = $clog2(LAT + 1);
  localparam logic signed [SW-1:0] HALF = SW'(64'sd1 <<< (FRAC-1));
  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [SW-1:0] MINV = SW'(-(64'sd1 <<< (DW-1)));

  logic [PW-1:0]            ph;
  logic [T-1:0][DW-1:0]     hist, hist_eff;
  logic [NC-1:0][CW-1:0]    coef;
  logic [T-1:0][DW-1:0]     st_h [T];
  logic [PW-1:0]            st_p [T];
  logic signed [SW-1:0]     prod [T];
  logic signed [SW-1:0]     ps   [T];
  logic signed [SW-1:0]     rnd;
  logic [LAT-1:0]           vpipe;
  logic [DW-1:0]            newest;

  assign newest    = sym_valid ? sym_data : '0;
  assign sym_ready = enable && (ph == '0);
  assign hist_eff  = sym_ready ? {hist[T-2:0], newest} : hist;
  assign out_valid = vpipe[LAT-1];
  assign rnd       = (ps[T-1] + HALF) >>> FRAC;

  for (genvar k = 0; k < T; k++) begin : g_tap
    assign prod[k] = SW'(signed'(st_h[k][k]))
                   * SW'(signed'(coef[AW'(st_p[k]) * AW'(T) + AW'(k)]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      hist     <= '0;
      coef     <= '0;
      vpipe    <= '0;
      out_data <= '0;
      for (int k = 0; k < T; k++) begin
        st_h[k] <= '0;
        st_p[k] <= '0;
        ps[k]   <= '0;
      end
    end else begin
      vpipe <= {vpipe[LAT-2:0], enable};
      if (enable) begin
        hist <= hist_eff;
        ph   <= (ph == PW'(L-1)) ? '0 : ph + 1'b1;
      end else begin
        ph <= '0;
        if (coef_we) coef[coef_addr] <= coef_data;
      end
      st_h[0] <= hist_eff;
      st_p[0] <= ph;
      ps[0]   <= prod[0];
      for (int k = 1; k < T; k++) begin
        st_h[k] <= st_h[k-1];
        st_p[k] <= st_p[k-1];
        ps[k]   <= ps[k-1] + prod[k];
      end
      out_data <= (rnd > MAXV) ? MAXV[DW-1:0] :
                  (rnd < MINV) ? MINV[DW-1:0] : rnd[DW-1:0];
    end
  end

  logic [RW-1:0] en_run;
  always_ff @(posedge clk) begin
    if (rst || !enable) en_run <= '0;
    else if (en_run != RW'(LAT)) en_run <= en_run + 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> !out_valid && hist == '0 && ph == '0 && out_data == '0);

  if (L > 1) begin : g_gap
    p_ready_gap_r2: assert property (@(posedge clk) disable iff (rst)
      sym_ready |=> !sym_ready);
  end

  p_hist_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !sym_ready |=> $stable(hist));

  p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
    en_run == RW'(LAT) |-> out_valid);

  p_sign_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(ps[T-1][SW-1]) |-> !out_data[DW-1]);

  p_coef_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    enable |=> $stable(coef));
endmodule

// File: tb/pulse_interp_tb.sv
module pulse_interp_tb;
  localparam int L = 4, M = 2, T = 2*M+1, NC = L*T, LAT = T+2, FRAC = 15, N = 64;

  logic clk = 0, rst = 1, enable = 0, sym_valid = 0, coef_we = 0;
  logic [15:0] sym_data = '0, coef_data = '0;
  logic [$clog2(NC)-1:0] coef_addr = '0;
  logic sym_ready, out_valid;
  logic [15:0] out_data;

  pulse_interp #(.DW(16), .CW(16), .L(L), .M(M), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .sym_valid(sym_valid),
    .sym_data(sym_data), .sym_ready(sym_ready), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_data(coef_data), .out_valid(out_valid),
    .out_data(out_data));

  always #10 clk = ~clk;

  int total = 0, fails = 0, cyc = 0, bph = 0;
  int mc [NC];
  int bh [T];
  bit ev [N];
  int ey [N];
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model();
    longint acc = 0;
    longint r;
    for (int k = 0; k < T; k++) acc += longint'(mc[bph*T+k]) * longint'(bh[k]);
    r = (acc + (64'sd1 <<< (FRAC-1))) >>> FRAC;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int rnd16();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr));
  endfunction

  task automatic tick(input bit en, input bit v, input int d, input bit we,
                      input int wa, input int wd, input string tag);
    int slot;
    enable = en; sym_valid = v; sym_data = 16'(d);
    coef_we = we; coef_addr = $bits(coef_addr)'(wa); coef_data = 16'(wd);
    #1;
    chk(sym_ready == (en && bph == 0), "R2 sym_ready", sym_ready, en && bph == 0);
    slot = (cyc + LAT) % N;
    if (en) begin
      if (bph == 0) begin
        for (int k = T-1; k > 0; k--) bh[k] = bh[k-1];
        bh[0] = v ? d : 0;
      end
      ev[slot] = 1;
      ey[slot] = model();
      bph = (bph + 1) % L;
    end else begin
      bph = 0;
      if (we) mc[wa] = wd;
    end
    @(posedge clk); @(negedge clk);
    cyc++;
    chk(out_valid == ev[cyc%N], "R6 out_valid", out_valid, ev[cyc%N]);
    if (ev[cyc%N])
      chk(int'($signed(out_data)) == ey[cyc%N], tag, $signed(out_data), ey[cyc%N]);
    ev[cyc%N] = 0;
  endtask

  task automatic t_reset();
    rst = 1; enable = 0; coef_we = 0; sym_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    bph = 0;
    for (int i = 0; i < NC; i++) mc[i] = 0;
    for (int k = 0; k < T; k++) bh[k] = 0;
    for (int i = 0; i < N; i++) ev[i] = 0;
    #1;
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(sym_ready == 0, "R1 sym_ready", sym_ready, 0);
    chk(out_data == 0, "R1 out_data", out_data, 0);
  endtask

  task automatic t_load(input int sel);
    for (int i = 0; i < NC; i++)
      tick(0, 0, 0, 1, i, sel ? 32767 : ((i % 2) ? -(i*1300+77) : (i*1500+123)), "R8 load");
  endtask

  task automatic t_impulse();
    tick(1, 1, 16384, 0, 0, 0, "R4 impulse phase");
    for (int i = 1; i < 3*L*T; i++) tick(1, 0, 0, 0, 0, 0, "R4 impulse phase");
  endtask

  task automatic t_stream(input int n, input bit gaps, input string tag);
    for (int i = 0; i < n; i++) begin
      int d = rnd16();
      tick(1, gaps ? lfsr[3] : 1'b1, d, 0, 0, 0, tag);
    end
  endtask

  task automatic t_hold();
    t_stream(2*L*T, 0, "R3 fill");
    for (int i = 0; i < 12; i++) tick(0, 1, 999, 0, 0, 0, "R5 paused");
    t_stream(3*L*T, 1, "R5 resume gaps");
  endtask

  task automatic t_frozen();
    for (int i = 0; i < 4*L; i++) begin
      int d = rnd16();
      tick(1, 1, d, 1, i % NC, 5, "R8 write while running");
    end
    for (int i = 0; i < LAT; i++) tick(0, 0, 0, 0, 0, 0, "R6 drain");
  endtask

  task automatic t_sat();
    for (int i = 0; i < 3*L; i++) tick(1, 1, 32767, 0, 0, 0, "R7 saturate high");
    for (int i = 0; i < 3*L; i++) tick(1, 1, -32768, 0, 0, 0, "R7 saturate low");
    for (int i = 0; i < LAT; i++) tick(0, 0, 0, 0, 0, 0, "R6 drain");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_impulse();
    for (int i = 0; i < LAT; i++) tick(0, 0, 0, 0, 0, 0, "R6 drain");
    t_load(0);
    t_impulse();
    t_stream(4*L*T, 0, "R3 random");
    t_stream(4*L*T, 1, "R5 gaps");
    t_hold();
    t_frozen();
    t_reset();
    t_load(1);
    t_sat();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule